// File: doc/BRIEF.md
# Spread-Spectrum Switching-Cycle Generator

This block times the switching cycles of a current-mode flyback controller from a fast system clock. Each switching period begins with a one-clock start strobe and a rising gate-enable; the pulse then ends on the first of three causes: a peak-current comparator trip, a current-limit comparator trip, or the maximum duty limit. Both trip inputs are masked for a short window after turn-on, the blanking window, to reject the turn-on spike. A trip that arrives after blanking but before the minimum on-time is held and acted on once that time has passed.

To spread conducted emissions, the period length moves in a triangle around its nominal value. An up/down offset counter advances once every few switching periods and reverses at plus and minus a set deviation, so one full up-and-down sweep lasts about 4 ms. The nominal rate is 60 kHz or 115 kHz, chosen by a parameter, with a deviation of about 4 kHz or 8 kHz. A burst request from the light-load comparator is sampled at each period boundary. While it is high, no cycle starts, but period timing and the sweep keep running. A low enable forces the gate off at once, without waiting for a clock edge, and returns all counters to their start values.

Top module: `spread_pwm_osc`

## Requirements
- R1: After reset with enable low, gate_o, cycle_start_o, off_phase_o and blank_o are all 0.
- R2: cycle_start_o is a one-clock pulse in the first clock of every started cycle, and gate_o is 1 in that clock. The first cycle starts on the first clock edge at which enable_i is high.
- R3: The period in clocks is P = NOM_PERIOD + d. The offset d is 0 after enable. It changes by STEP_CYC once every ADV_DIV periods, rising to +DEV_CYC and then falling to -DEV_CYC; a step that would pass either bound lands on the bound and reverses direction.
- R4: With no trip, gate_o is high for exactly floor(P * DUTY_Q8 / 256) clocks from the start of the cycle.
- R5: blank_o is high during the first BLANK_CYC clocks of each gate pulse, and any trip sampled in those clocks is ignored.
- R6: A trip on either input sampled at cycle position t >= BLANK_CYC, where position 0 is the start clock, gives a pulse of max(t+1, MIN_ON_CYC) clocks, capped by the R4 duty limit. A trip held high for the whole cycle gives max(BLANK_CYC+1, MIN_ON_CYC) clocks.
- R7: Within a started cycle, off_phase_o is high exactly in the clocks where gate_o is low. It is 0 in skipped periods and while disabled. Each cycle has a single contiguous gate pulse.
- R8: burst_req_i is sampled at each period boundary. While it is high, no cycle starts and the gate stays low. The first boundary after it clears starts a cycle.
- R9: While enable_i is low, gate_o is 0 with no clock edge needed, and the period, offset and sweep counters return to their start values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Global run enable; low clears the gate asynchronously |
| burst_req_i | input | 1 | Light-load request to skip cycles |
| cs_trip_i | input | 1 | Peak-current (PWM comparator) trip |
| ilim_trip_i | input | 1 | Current-limit comparator trip |
| gate_o | output | 1 | Gate-enable to the driver |
| cycle_start_o | output | 1 | One-clock strobe at each started cycle |
| off_phase_o | output | 1 | High during the off part of a started cycle |
| blank_o | output | 1 | Leading-edge blanking window |

## Verification
The case that is hardest to reach from the ports is a trip that lands in the narrow band after blanking has ended but before the minimum on-time. The pulse must then stretch to the minimum length, and the trip position must be measured against a period length that the sweep keeps changing. The stimulus moves the trip position by one clock in each successive period, over every position from the start clock to past the duty limit, and alternates between the two trip inputs. At the same time the bench follows the triangle offset, so every period length and pulse width is compared against an arithmetic expectation.

// File: rtl/ssc_pkg.sv
// Package: shared types and elaboration-time helpers for the
// spread-spectrum switching-cycle generator.
// Assumes all arguments are positive integers.
package ssc_pkg;

    typedef enum logic {
        SWEEP_UP   = 1'b0,
        SWEEP_DOWN = 1'b1
    } sweep_dir_e;

    // Integer ceiling division for parameter derivation.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // Larger of two integers for parameter derivation.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ssc_tri_mod.sv
// Triangle offset generator. Advances a signed offset by STEP_CYC
// once every ADV_DIV assertions of adv_i, bouncing between -DEV_CYC
// and +DEV_CYC. Assumes DEV_CYC >= 1 and STEP_CYC >= 1.
// Disable returns offset, direction and divider to their start values.
module ssc_tri_mod
    import ssc_pkg::*;
#(
    parameter int DEV_CYC  = 6,
    parameter int STEP_CYC = 2,
    parameter int ADV_DIV  = 2,
    localparam int OFF_W   = $clog2(DEV_CYC + 1) + 1,
    localparam int DIV_W   = $clog2(ADV_DIV + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_i,
    input  logic                    adv_i,
    output logic signed [OFF_W-1:0] offset_o
);

    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(ADV_DIV - 1);

    logic signed [OFF_W-1:0] off_q;
    sweep_dir_e              dir_q;
    logic [DIV_W-1:0]        div_q;
    logic signed [OFF_W-1:0] off_nxt;
    sweep_dir_e              dir_nxt;

    // Compute the next offset and direction for one sweep step.
    always_comb begin
        int cur;
        cur     = int'(off_q);
        off_nxt = off_q;
        dir_nxt = dir_q;
        if (dir_q == SWEEP_UP) begin
            if (cur >= DEV_CYC - STEP_CYC) begin
                off_nxt = OFF_W'(DEV_CYC);
                dir_nxt = SWEEP_DOWN;
            end else begin
                off_nxt = OFF_W'(cur + STEP_CYC);
            end
        end else begin
            if (cur <= STEP_CYC - DEV_CYC) begin
                off_nxt = OFF_W'(-DEV_CYC);
                dir_nxt = SWEEP_UP;
            end else begin
                off_nxt = OFF_W'(cur - STEP_CYC);
            end
        end
    end

    // Hold or advance the sweep state once per divided period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            off_q <= '0;
            dir_q <= SWEEP_UP;
            div_q <= '0;
        end else if (adv_i) begin
            if (div_q == DIV_LAST) begin
                div_q <= '0;
                off_q <= off_nxt;
                dir_q <= dir_nxt;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign offset_o = off_q;

endmodule

// File: rtl/ssc_period_timer.sv
// Period timer. Counts clock positions within the current switching
// period and latches the next period length and its duty-limited
// on-time at every wrap. Assumes NOM_PERIOD > DEV_CYC + 1.
// While disabled it parks on the last position of a nominal period so
// the first enabled edge wraps at once.
module ssc_period_timer #(
    parameter int NOM_PERIOD = 40,
    parameter int DEV_CYC    = 6,
    parameter int DUTY_Q8    = 192,
    localparam int OFF_W     = $clog2(DEV_CYC + 1) + 1,
    localparam int CNT_W     = $clog2(NOM_PERIOD + DEV_CYC + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_i,
    input  logic signed [OFF_W-1:0] offset_i,
    output logic                    wrap_o,
    output logic [CNT_W-1:0]        pos_o,
    output logic [CNT_W-1:0]        on_max_o
);

    localparam logic [CNT_W-1:0] NOM_L      = CNT_W'(NOM_PERIOD);
    localparam logic [CNT_W-1:0] NOM_LAST_L = CNT_W'(NOM_PERIOD - 1);
    localparam logic [CNT_W-1:0] NOM_ON_L   = CNT_W'((NOM_PERIOD * DUTY_Q8) / 256);

    logic [CNT_W-1:0] pos_q;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] on_max_q;
    logic [CNT_W-1:0] per_nxt;
    logic [CNT_W-1:0] on_nxt;

    // Derive the next period length and its duty-limited on-time.
    always_comb begin
        int plen;
        int olen;
        plen    = NOM_PERIOD + int'(offset_i);
        olen    = (plen * DUTY_Q8) / 256;
        per_nxt = plen[CNT_W-1:0];
        on_nxt  = olen[CNT_W-1:0];
    end

    assign wrap_o = en_i && (pos_q == per_q - 1'b1);

    // Advance the position counter and latch period data at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            pos_q    <= NOM_LAST_L;
            per_q    <= NOM_L;
            on_max_q <= NOM_ON_L;
        end else if (wrap_o) begin
            pos_q    <= '0;
            per_q    <= per_nxt;
            on_max_q <= on_nxt;
        end else begin
            pos_q <= pos_q + 1'b1;
        end
    end

    assign pos_o    = pos_q;
    assign on_max_o = on_max_q;

endmodule

// File: rtl/ssc_gate_ctrl.sv
// Gate controller. Opens the gate at each wrap unless a burst is
// requested, masks trips during blanking, holds early trips until the
// minimum on-time, and ends the pulse at the duty limit.
// Assumes MIN_ON_CYC <= on-time limit of the shortest period.
module ssc_gate_ctrl #(
    parameter int CNT_W      = 6,
    parameter int BLANK_CYC  = 3,
    parameter int MIN_ON_CYC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             wrap_i,
    input  logic             burst_i,
    input  logic             cs_trip_i,
    input  logic             ilim_trip_i,
    input  logic [CNT_W-1:0] pos_i,
    input  logic [CNT_W-1:0] on_max_i,
    output logic             gate_q_o,
    output logic             active_o
);

    localparam logic [CNT_W-1:0] BLANK_L   = CNT_W'(BLANK_CYC);
    localparam logic [CNT_W-1:0] MIN_END_L = CNT_W'(MIN_ON_CYC - 1);

    logic gate_q;
    logic active_q;
    logic pend_q;
    logic trip_seen;
    logic at_limit;
    logic min_met;

    // Qualify trips outside blanking and find the pulse end points.
    always_comb begin
        trip_seen = (cs_trip_i || ilim_trip_i) && (pos_i >= BLANK_L);
        at_limit  = (pos_i + 1'b1) >= on_max_i;
        min_met   = pos_i >= MIN_END_L;
    end

    // Open, hold or close the gate for the current cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            gate_q   <= 1'b0;
            active_q <= 1'b0;
            pend_q   <= 1'b0;
        end else if (wrap_i) begin
            gate_q   <= !burst_i;
            active_q <= !burst_i;
            pend_q   <= 1'b0;
        end else if (gate_q) begin
            if (at_limit) begin
                gate_q <= 1'b0;
            end else if ((trip_seen || pend_q) && min_met) begin
                gate_q <= 1'b0;
            end else if (trip_seen) begin
                pend_q <= 1'b1;
            end
        end
    end

    assign gate_q_o = gate_q;
    assign active_o = active_q;

endmodule

// File: rtl/spread_pwm_osc.sv
// Top: spread-spectrum switching-cycle generator. Ties the triangle
// sweep, the period timer and the gate controller together and forms
// the port-level strobes. The gate output is forced low by enable
// without waiting for a clock edge. Comparator inputs are assumed
// synchronous to clk.
module spread_pwm_osc
    import ssc_pkg::*;
#(
    parameter int CLK_HZ     = 100_000_000,
    parameter bit HIGH_FREQ  = 1'b0,
    parameter int FSW_HZ     = HIGH_FREQ ? 115_000 : 60_000,
    parameter int DEV_HZ     = HIGH_FREQ ? 8_000 : 4_000,
    parameter int NOM_PERIOD = CLK_HZ / FSW_HZ,
    parameter int DEV_CYC    = imax(1, (NOM_PERIOD * DEV_HZ) / FSW_HZ),
    parameter int SWEEP_PER  = FSW_HZ / 250,
    parameter int STEP_CYC   = imax(1, ceil_div(4 * DEV_CYC, SWEEP_PER)),
    parameter int ADV_DIV    = imax(1, (SWEEP_PER * STEP_CYC + 2 * DEV_CYC) / (4 * DEV_CYC)),
    parameter int DUTY_Q8    = 192,
    parameter int BLANK_CYC  = (CLK_HZ / 1_000_000) * 3 / 10,
    parameter int MIN_ON_CYC = (CLK_HZ / 1_000_000) * 4 / 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic burst_req_i,
    input  logic cs_trip_i,
    input  logic ilim_trip_i,
    output logic gate_o,
    output logic cycle_start_o,
    output logic off_phase_o,
    output logic blank_o
);

    localparam int OFF_W = $clog2(DEV_CYC + 1) + 1;
    localparam int CNT_W = $clog2(NOM_PERIOD + DEV_CYC + 1);
    localparam logic [CNT_W-1:0] BLANK_L = CNT_W'(BLANK_CYC);

    logic signed [OFF_W-1:0] offset;
    logic                    wrap;
    logic [CNT_W-1:0]        pos;
    logic [CNT_W-1:0]        on_max;
    logic                    gate_q;
    logic                    active;

    ssc_tri_mod #(
        .DEV_CYC  (DEV_CYC),
        .STEP_CYC (STEP_CYC),
        .ADV_DIV  (ADV_DIV)
    ) u_sweep (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (enable_i),
        .adv_i    (wrap),
        .offset_o (offset)
    );

    ssc_period_timer #(
        .NOM_PERIOD (NOM_PERIOD),
        .DEV_CYC    (DEV_CYC),
        .DUTY_Q8    (DUTY_Q8)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (enable_i),
        .offset_i (offset),
        .wrap_o   (wrap),
        .pos_o    (pos),
        .on_max_o (on_max)
    );

    ssc_gate_ctrl #(
        .CNT_W      (CNT_W),
        .BLANK_CYC  (BLANK_CYC),
        .MIN_ON_CYC (MIN_ON_CYC)
    ) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (enable_i),
        .wrap_i      (wrap),
        .burst_i     (burst_req_i),
        .cs_trip_i   (cs_trip_i),
        .ilim_trip_i (ilim_trip_i),
        .pos_i       (pos),
        .on_max_i    (on_max),
        .gate_q_o    (gate_q),
        .active_o    (active)
    );

    // Form the port-level gate and timing markers.
    always_comb begin
        gate_o        = gate_q && enable_i;
        cycle_start_o = enable_i && active && (pos == '0);
        off_phase_o   = enable_i && active && !gate_q;
        blank_o       = gate_o && (pos < BLANK_L);
    end

endmodule

// File: rtl/spread_pwm_osc_chk.sv
// Checker for spread_pwm_osc: port-level temporal properties, bound
// to every instance of the top. Tracks the running gate pulse length
// with its own counter.
module spread_pwm_osc_chk #(
    parameter int MIN_ON_CYC = 6,
    parameter int MAX_ON_CYC = 34
) (
    input logic clk,
    input logic rst_n,
    input logic enable_i,
    input logic burst_req_i,
    input logic gate_o,
    input logic cycle_start_o,
    input logic off_phase_o,
    input logic blank_o
);

    logic [15:0] hi_cnt;

    // Count consecutive clocks with the gate high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (gate_o) begin
            if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
        end else begin
            hi_cnt <= '0;
        end
    end

    a_r9_gate_low_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |-> !gate_o);

    a_r2_start_has_gate: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start_o |-> gate_o);

    a_r5_blank_inside_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        blank_o |-> gate_o);

    a_r7_off_excludes_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !(off_phase_o && gate_o));

    a_r6_min_on_time: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gate_o) && enable_i && $past(enable_i)) |-> (hi_cnt >= 16'(MIN_ON_CYC)));

    a_r4_duty_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o |-> (hi_cnt < 16'(MAX_ON_CYC)));

    a_r8_no_start_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start_o |-> !$past(burst_req_i));

endmodule

bind spread_pwm_osc spread_pwm_osc_chk #(
    .MIN_ON_CYC (MIN_ON_CYC),
    .MAX_ON_CYC (((NOM_PERIOD + DEV_CYC) * DUTY_Q8) / 256)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable_i      (enable_i),
    .burst_req_i   (burst_req_i),
    .gate_o        (gate_o),
    .cycle_start_o (cycle_start_o),
    .off_phase_o   (off_phase_o),
    .blank_o       (blank_o)
);

// File: tb/spread_pwm_osc_bench.sv
// Bench: small configuration, trip position swept across all clock
// positions while the period sweep is tracked arithmetically.
module spread_pwm_osc_bench;

    localparam int NOM   = 40;
    localparam int DEV   = 6;
    localparam int STEP  = 2;
    localparam int DIV   = 2;
    localparam int DUTY  = 192;
    localparam int BLANK = 3;
    localparam int MINON = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable_i = 1'b0;
    logic burst_req_i = 1'b0;
    logic cs_trip_i = 1'b0;
    logic ilim_trip_i = 1'b0;
    logic gate_o, cycle_start_o, off_phase_o, blank_o;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    int m_off = 0;
    int m_dir = 1;
    int m_div = 0;

    always #5 clk = ~clk;

    spread_pwm_osc #(
        .NOM_PERIOD (NOM),
        .DEV_CYC    (DEV),
        .STEP_CYC   (STEP),
        .ADV_DIV    (DIV),
        .DUTY_Q8    (DUTY),
        .BLANK_CYC  (BLANK),
        .MIN_ON_CYC (MINON)
    ) u_spread_pwm_osc (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable_i      (enable_i),
        .burst_req_i   (burst_req_i),
        .cs_trip_i     (cs_trip_i),
        .ilim_trip_i   (ilim_trip_i),
        .gate_o        (gate_o),
        .cycle_start_o (cycle_start_o),
        .off_phase_o   (off_phase_o),
        .blank_o       (blank_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    function automatic int imx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // R3 sweep model: step every DIV periods, clip at the bounds and turn.
    task automatic model_advance();
        if (m_div == DIV - 1) begin
            m_div = 0;
            if (m_dir > 0) begin
                if (m_off + STEP >= DEV) begin m_off = DEV; m_dir = -1; end
                else m_off = m_off + STEP;
            end else begin
                if (m_off - STEP <= -DEV) begin m_off = -DEV; m_dir = 1; end
                else m_off = m_off - STEP;
            end
        end else begin
            m_div++;
        end
    endtask

    task automatic model_reset();
        m_off = 0; m_dir = 1; m_div = 0;
    endtask

    // Measure one started cycle from its start negedge; tpos -1 none, -2 held.
    task automatic measure(input int tpos, input bit use_il,
                           output int len, output int gh, output int bh, output int oh);
        int pos;
        bit t;
        pos = 0; gh = 0; bh = 0; oh = 0;
        while (1) begin
            t = (tpos == -2) || (tpos == pos);
            cs_trip_i   = t && !use_il;
            ilim_trip_i = t && use_il;
            gh += int'(gate_o);
            bh += int'(blank_o);
            oh += int'(off_phase_o);
            @(negedge clk);
            pos++;
            if (cycle_start_o || pos > 200) break;
        end
        cs_trip_i = 1'b0;
        ilim_trip_i = 1'b0;
        len = pos;
    endtask

    // Measure a cycle and compare length, pulse, blanking and off time.
    task automatic check_cycle(input int tpos, input bit use_il);
        int p, om, w, len, gh, bh, oh;
        p  = NOM + m_off;
        om = (p * DUTY) / 256;
        if (tpos == -1)          w = om;
        else if (tpos == -2)     w = imin(om, imx(MINON, BLANK + 1));
        else if (tpos < BLANK)   w = om;
        else                     w = imin(om, imx(tpos + 1, MINON));
        measure(tpos, use_il, len, gh, bh, oh);
        chk("R3 period length", len, p);
        if (tpos == -1) chk("R4 duty-limited width", gh, w);
        else if (tpos >= 0 && tpos < BLANK) chk("R5 trip in blanking ignored", gh, w);
        else chk("R6 trip-ended width", gh, w);
        chk("R5 blanking length", bh, imin(BLANK, w));
        chk("R7 off-phase length", oh, p - w);
        model_advance();
    endtask

    initial begin
        int gh, oh, cs, waitc, p, om;
        bit found;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 gate in reset", int'(gate_o), 0);
        chk("R1 start in reset", int'(cycle_start_o), 0);
        chk("R1 off in reset", int'(off_phase_o), 0);
        chk("R1 blank in reset", int'(blank_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 gate idle after reset", int'(gate_o), 0);

        enable_i = 1'b1;
        model_reset();
        @(negedge clk);
        chk("R2 first start on first enabled edge", int'(cycle_start_o), 1);
        chk("R2 gate at start", int'(gate_o), 1);

        // R3-R7: trip position swept, alternating trip inputs
        for (int k = 0; k < 60; k++) begin
            int tp;
            if (k < 2 || k >= 48) tp = -1;
            else if (k >= 45)     tp = -2;
            else                  tp = k - 2;
            check_cycle(tp, k[0]);
        end

        // R8: burst request skips cycles
        p  = NOM + m_off;
        om = (p * DUTY) / 256;
        burst_req_i = 1'b1;
        gh = 0; oh = 0; cs = 0;
        for (int i = 0; i < 100; i++) begin
            gh += int'(gate_o);
            oh += int'(off_phase_o);
            if (i > 0) cs += int'(cycle_start_o);
            @(negedge clk);
        end
        chk("R8 only current pulse during burst", gh, om);
        chk("R8 no starts during burst", cs, 0);
        chk("R7 off-phase low in skipped periods", oh, p - om);
        burst_req_i = 1'b0;
        found = 1'b0; waitc = 0;
        for (int i = 0; i < 60 && !found; i++) begin
            @(negedge clk);
            waitc++;
            if (cycle_start_o) found = 1'b1;
        end
        chk("R8 switching resumes after burst", int'(found), 1);
        chk("R8 resume within one period", int'(waitc <= NOM + DEV), 1);
        chk("R2 gate at resumed start", int'(gate_o), 1);

        // R9: enable drop clears gate without a clock edge
        @(negedge clk);
        @(negedge clk);
        chk("R9 gate high before disable", int'(gate_o), 1);
        enable_i = 1'b0;
        #1;
        chk("R9 gate low at once on disable", int'(gate_o), 0);
        repeat (3) @(negedge clk);
        chk("R9 no start while disabled", int'(cycle_start_o), 0);
        chk("R9 off-phase low while disabled", int'(off_phase_o), 0);
        chk("R9 blank low while disabled", int'(blank_o), 0);
        enable_i = 1'b1;
        model_reset();
        @(negedge clk);
        chk("R2 restart on first enabled edge", int'(cycle_start_o), 1);
        for (int k = 0; k < 6; k++) check_cycle(-1, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog R2: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule